// File: doc/BRIEF.md
# Quad-Channel Serial DAC Write Sequencer

This block sits on the host side of a four-channel, 12-bit serial digital-to-analog converter. It turns each accepted write into a 16-bit serial frame. After the frame it drives a strobe that latches the word into the selected channel's input register. A second strobe moves every input register into the output registers at once. The block also drives the device's reset line and its reset-level select pin. Every pin edge is placed by a down-counter. Each interval is a parameter counted in system-clock cycles, so one RTL meets the converter's nanosecond limits at any clock rate.

Writes arrive on a valid/ready stream that carries a channel number and a code. A write is taken on a cycle where both `in_valid` and `in_ready` are high, and `auto_upd` is sampled on that same cycle. `in_ready` is low from the cycle after acceptance until the last strobe of that operation has returned high and a guard gap has passed. While `in_ready` is low the source must hold its item. A device reset that is still waiting also keeps `in_ready` low, so a waiting reset goes ahead of a waiting write. A global update is requested with a one-cycle pulse on `upd_req`. A device reset is requested with a one-cycle pulse on `rst_req`, and `rst_mode` on that cycle gives the reset level. The block remembers both pulses until it can serve them.

Top module: `dac_wr_seq`

## Requirements
- R1: After reset, `dac_cs_n`, `dac_sck`, `dac_ldreg_n`, `dac_lddac_n` and `dac_rst_n` are high, `dac_sdi` and `dac_rstsel` are low, and `in_ready` is high.
- R2: Each write sends one frame, sampled by the device on rising `dac_sck` edges and sent first bit first. Frame bit 15 is `in_chan[1]` and bit 14 is `in_chan[0]`. Bits 13..12 are zero. Bits 11..0 are the code, most significant bit first.
- R3: Every chip-select window holds exactly 16 rising clock edges. `dac_sck` is high whenever `dac_cs_n` is high, and it is high on the cycle where `dac_cs_n` rises.
- R4: A clock low phase lasts at least T_CL cycles and a high phase at least T_CH cycles. `dac_sdi` changes only on the cycle the clock falls. It is stable for at least 7 cycles before each rising edge and for at least 5 cycles after it.
- R5: `dac_cs_n` falls at least 14 cycles before the first rising clock edge. It rises at least 4 cycles after the last rising edge.
- R6: `dac_ldreg_n` stays high while `dac_cs_n` is low. It falls only after chip-select has risen, at least 4 cycles after the last rising clock edge. It then stays low for exactly T_LDW cycles. The word latched is the one just shifted.
- R7: `dac_lddac_n` pulses low for exactly T_LDDW cycles after the register load of a write accepted with `auto_upd` high. It also pulses once for each served `upd_req`, and such a pulse causes no chip-select activity. A write without `auto_upd`, with no update waiting, causes no such pulse.
- R8: On a reset request, `dac_rstsel` takes the requested level at least 7 cycles before `dac_rst_n` falls. It holds that level while `dac_rst_n` is low, and `dac_rst_n` stays low for exactly T_RSTW cycles. A reset requested during a write is served before the next write is accepted.
- R9: `in_ready` is high only when every strobe and chip-select is inactive. It is low on the cycle after a write is accepted.
- R10: At most one of chip-select, register load, global update and device reset is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| in_valid | input | 1 | Write item valid |
| in_ready | output | 1 | Sequencer can take a write |
| in_chan | input | 2 | Target channel of the write |
| in_code | input | 12 | Straight-binary code for the channel |
| auto_upd | input | 1 | Issue a global update after this write (sampled with the write) |
| upd_req | input | 1 | One-cycle request for a global output update |
| rst_req | input | 1 | One-cycle request for a device reset |
| rst_mode | input | 1 | Reset level with `rst_req`: 0 zero-scale, 1 mid-scale |
| dac_cs_n | output | 1 | Device chip-select, active low |
| dac_sck | output | 1 | Serial clock, rests high |
| dac_sdi | output | 1 | Serial data to the device |
| dac_ldreg_n | output | 1 | Input-register load strobe, active low |
| dac_lddac_n | output | 1 | All-output load strobe, active low |
| dac_rst_n | output | 1 | Device reset, active low |
| dac_rstsel | output | 1 | Device reset-level select |

## Verification
The hardest case to reach is a device reset that arrives while a frame is on the wire. It must wait for the shift, deselect and register load to finish, and it must then win over a write that is already offered. The stimulus pulses `rst_req` part-way through a frame and offers the next write at once. The bench then checks that the write is accepted only after the reset pulse has been counted. An update pulse that arrives during a write without auto-update is also sent mid-frame, to check that it is held and served right after that write's register load.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SELECT,
    S_SCK_LO,
    S_SCK_HI,
    S_DESEL,
    S_LOAD,
    S_UPDATE,
    S_RSEL,
    S_RESET,
    S_GAP
  } seq_state_e;

endpackage

// File: rtl/dacseq_timer.sv
module dacseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  // A load of N keeps 'expired' low for N-1 cycles, so the state that
  // issued the load is held for exactly N cycles (N must be at least 1).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= (load_val == '0) ? '0 : load_val - W'(1);
    else if (cnt != '0)        cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dacseq_shifter.sv
module dacseq_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         bit_out
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sreg <= '0;
    else if (load)   sreg <= load_word;
    else if (shift)  sreg <= {sreg[W-2:0], 1'b0};
  end

  assign bit_out = sreg[W-1];
endmodule

// File: rtl/dacseq_pins.sv
module dacseq_pins
  import dacseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state,
  input  logic       data_bit,
  input  logic       rsel_lvl,
  output logic       cs_n,
  output logic       sck,
  output logic       sdi,
  output logic       ldreg_n,
  output logic       lddac_n,
  output logic       dev_rst_n,
  output logic       rstsel
);
  logic selected;

  always_comb begin
    unique case (state)
      S_SELECT, S_SCK_LO, S_SCK_HI, S_DESEL: selected = 1'b1;
      default:                              selected = 1'b0;
    endcase
  end

  // Registered decode keeps every device pin glitch-free.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n      <= 1'b1;
      sck       <= 1'b1;
      sdi       <= 1'b0;
      ldreg_n   <= 1'b1;
      lddac_n   <= 1'b1;
      dev_rst_n <= 1'b1;
      rstsel    <= 1'b0;
    end else begin
      cs_n      <= !selected;
      sck       <= (state != S_SCK_LO);
      sdi       <= data_bit;
      ldreg_n   <= (state != S_LOAD);
      lddac_n   <= (state != S_UPDATE);
      dev_rst_n <= (state != S_RESET);
      rstsel    <= rsel_lvl;
    end
  end
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dacseq_pkg::*;
#(
  parameter int CHAN_W  = 2,
  parameter int PAD_W   = 2,
  parameter int CODE_W  = 12,
  parameter int TIMER_W = 8,
  parameter int T_CSS   = 14,  // select to first low phase
  parameter int T_CL    = 13,  // clock low phase
  parameter int T_CH    = 8,   // clock high phase
  parameter int T_CSH   = 4,   // extra high time before chip-select rises
  parameter int T_LD2   = 4,   // extra time before the register load may fall
  parameter int T_LDW   = 12,  // register load low width
  parameter int T_LDDW  = 12,  // global update low width
  parameter int T_RSSH  = 7,   // reset-select setup before reset falls
  parameter int T_RSTW  = 18,  // reset low width
  parameter int T_GAP   = 2    // guard gap after every operation
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [CODE_W-1:0] in_code,
  input  logic              auto_upd,
  input  logic              upd_req,
  input  logic              rst_req,
  input  logic              rst_mode,
  output logic              dac_cs_n,
  output logic              dac_sck,
  output logic              dac_sdi,
  output logic              dac_ldreg_n,
  output logic              dac_lddac_n,
  output logic              dac_rst_n,
  output logic              dac_rstsel
);
  localparam int FRAME_W = CHAN_W + PAD_W + CODE_W;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int T_TAIL  = (T_CSH > T_LD2) ? T_CSH : T_LD2;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  seq_state_e           state, nstate;
  logic                 tmr_load, tmr_done;
  logic [TIMER_W-1:0]   tmr_val;
  logic                 frm_load, frm_shift, frm_bit;
  logic [BIT_W-1:0]     bit_cnt;
  logic                 auto_q, upd_pend, rst_pend, rmode_pend, rsel_q;
  logic                 accept;
  logic [FRAME_W-1:0]   frame;

  assign in_ready = (state == S_IDLE) && !rst_pend;
  assign accept   = in_valid && in_ready;
  assign frame    = {in_chan, {PAD_W{1'b0}}, in_code};

  always_comb begin
    nstate    = state;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    frm_load  = 1'b0;
    frm_shift = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (rst_pend) begin
          nstate = S_RSEL;   tmr_load = 1'b1; tmr_val = TIMER_W'(T_RSSH);
        end else if (in_valid) begin
          nstate = S_SELECT; tmr_load = 1'b1; tmr_val = TIMER_W'(T_CSS);
          frm_load = 1'b1;
        end else if (upd_pend) begin
          nstate = S_UPDATE; tmr_load = 1'b1; tmr_val = TIMER_W'(T_LDDW);
        end
      end
      S_SELECT: if (tmr_done) begin
        nstate = S_SCK_LO; tmr_load = 1'b1; tmr_val = TIMER_W'(T_CL);
      end
      S_SCK_LO: if (tmr_done) begin
        nstate = S_SCK_HI; tmr_load = 1'b1; tmr_val = TIMER_W'(T_CH);
      end
      S_SCK_HI: if (tmr_done) begin
        if (bit_cnt == LAST_BIT) begin
          nstate = S_DESEL;  tmr_load = 1'b1; tmr_val = TIMER_W'(T_TAIL);
        end else begin
          nstate = S_SCK_LO; tmr_load = 1'b1; tmr_val = TIMER_W'(T_CL);
          frm_shift = 1'b1;
        end
      end
      S_DESEL: if (tmr_done) begin
        nstate = S_LOAD; tmr_load = 1'b1; tmr_val = TIMER_W'(T_LDW);
      end
      S_LOAD: if (tmr_done) begin
        if (auto_q || upd_pend) begin
          nstate = S_UPDATE; tmr_load = 1'b1; tmr_val = TIMER_W'(T_LDDW);
        end else begin
          nstate = S_GAP;    tmr_load = 1'b1; tmr_val = TIMER_W'(T_GAP);
        end
      end
      S_UPDATE: if (tmr_done) begin
        nstate = S_GAP; tmr_load = 1'b1; tmr_val = TIMER_W'(T_GAP);
      end
      S_RSEL: if (tmr_done) begin
        nstate = S_RESET; tmr_load = 1'b1; tmr_val = TIMER_W'(T_RSTW);
      end
      S_RESET: if (tmr_done) begin
        nstate = S_GAP; tmr_load = 1'b1; tmr_val = TIMER_W'(T_GAP);
      end
      S_GAP: if (tmr_done) nstate = S_IDLE;
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bit_cnt    <= '0;
      auto_q     <= 1'b0;
      upd_pend   <= 1'b0;
      rst_pend   <= 1'b0;
      rmode_pend <= 1'b0;
      rsel_q     <= 1'b0;
    end else begin
      state <= nstate;
      if (state == S_SELECT) bit_cnt <= '0;
      else if (frm_shift)    bit_cnt <= bit_cnt + BIT_W'(1);
      if (accept) auto_q <= auto_upd;
      // A new request wins over the clear on the same cycle.
      if (upd_req)                                   upd_pend <= 1'b1;
      else if (nstate == S_UPDATE && state != S_UPDATE) upd_pend <= 1'b0;
      if (rst_req) begin
        rst_pend   <= 1'b1;
        rmode_pend <= rst_mode;
      end else if (state == S_IDLE && nstate == S_RSEL) begin
        rst_pend <= 1'b0;
      end
      if (state == S_IDLE && nstate == S_RSEL) rsel_q <= rmode_pend;
    end
  end

  dacseq_timer #(.W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  dacseq_shifter #(.W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frm_load),
    .load_word (frame),
    .shift     (frm_shift),
    .bit_out   (frm_bit)
  );

  dacseq_pins u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .data_bit  (frm_bit),
    .rsel_lvl  (rsel_q),
    .cs_n      (dac_cs_n),
    .sck       (dac_sck),
    .sdi       (dac_sdi),
    .ldreg_n   (dac_ldreg_n),
    .lddac_n   (dac_lddac_n),
    .dev_rst_n (dac_rst_n),
    .rstsel    (dac_rstsel)
  );
endmodule

// File: rtl/dacseq_chk.sv
module dacseq_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic dac_cs_n,
  input logic dac_sck,
  input logic dac_sdi,
  input logic dac_ldreg_n,
  input logic dac_lddac_n,
  input logic dac_rst_n,
  input logic dac_rstsel
);
  a_r3_clock_rests_high: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> dac_sck);

  a_r3_deselect_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> (dac_sck && $past(dac_sck)));

  a_r4_data_steady_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n && $past(!dac_cs_n) && dac_sck && $past(dac_sck)) |-> $stable(dac_sdi));

  a_r6_load_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ldreg_n |-> (dac_cs_n && dac_sck));

  a_r8_level_held_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_rst_n |-> $stable(dac_rstsel));

  a_r9_ready_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (dac_cs_n && dac_ldreg_n && dac_lddac_n && dac_rst_n));

  a_r9_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r10_single_activity: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!dac_cs_n, !dac_ldreg_n, !dac_lddac_n, !dac_rst_n}));
endmodule

bind dac_wr_seq dacseq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .dac_cs_n    (dac_cs_n),
  .dac_sck     (dac_sck),
  .dac_sdi     (dac_sdi),
  .dac_ldreg_n (dac_ldreg_n),
  .dac_lddac_n (dac_lddac_n),
  .dac_rst_n   (dac_rst_n),
  .dac_rstsel  (dac_rstsel)
);

// File: tb/sim_dac_wr_seq.sv
module sim_dac_wr_seq;
  localparam int CL = 13, CH = 8, LDW = 12, LDDW = 12, RSTW = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_chan = '0;
  logic [11:0] in_code = '0;
  logic auto_upd = 1'b0, upd_req = 1'b0, rst_req = 1'b0, rst_mode = 1'b0;
  logic cs_n, sck, sdi, ldreg_n, lddac_n, drst_n, rstsel;

  always #2 clk = ~clk;

  dac_wr_seq u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_code(in_code), .auto_upd(auto_upd),
    .upd_req(upd_req), .rst_req(rst_req), .rst_mode(rst_mode),
    .dac_cs_n(cs_n), .dac_sck(sck), .dac_sdi(sdi), .dac_ldreg_n(ldreg_n),
    .dac_lddac_n(lddac_n), .dac_rst_n(drst_n), .dac_rstsel(rstsel)
  );

  int checks = 0, errors = 0;
  logic [13:0] exp_q[$];
  int exp_upd = 0, upd_seen = 0, rst_seen = 0, frames = 0;
  logic exp_rsel = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: decodes the serial bus at the falling system-clock edge.
  logic p_cs = 1'b1, p_sck = 1'b1, p_sdi = 1'b0, p_ld = 1'b1, p_upd = 1'b1, p_rst = 1'b1, p_rs = 1'b0;
  int run_sck = 0, run_sdi = 0, run_ld = 0, run_upd = 0, run_rst = 0, run_rs = 0;
  int since_cs = 0, since_rise = 0, bits = 0;
  logic [15:0] shreg = '0, got = '0;
  logic busy_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready && !(cs_n && ldreg_n && lddac_n && drst_n)) busy_seen = 1'b1;
      since_cs++; since_rise++;
      if (p_cs && !cs_n) begin since_cs = 0; bits = 0; shreg = '0; end
      if (sdi !== p_sdi) begin
        if (!cs_n && bits > 0) chk(since_rise >= 5, "R4 data hold after rise", since_rise, 5);
        if (!cs_n && bits > 0) chk(!sck && p_sck, "R4 data moves with clock fall", sck, 0);
        run_sdi = 1;
      end else run_sdi++;
      if (sck !== p_sck) begin
        if (sck && !cs_n) begin
          chk(run_sck >= CL, "R4 clock low width", run_sck, CL);
          chk(run_sdi >= 7, "R4 data setup before rise", run_sdi, 7);
          if (bits == 0) chk(since_cs >= 14, "R5 select to first rise", since_cs, 14);
          shreg = {shreg[14:0], sdi}; bits++; since_rise = 0;
        end else if (!sck && bits > 0) begin
          chk(run_sck >= CH, "R4 clock high width", run_sck, CH);
        end
        run_sck = 1;
      end else run_sck++;
      if (!p_cs && cs_n) begin
        chk(sck === 1'b1, "R3 clock high at deselect", sck, 1);
        chk(bits == 16, "R3 rising edges per frame", bits, 16);
        chk(since_rise >= 4, "R5 last rise to deselect", since_rise, 4);
        got = shreg; frames++;
      end
      if (ldreg_n !== p_ld) begin
        if (!ldreg_n) begin
          chk(cs_n === 1'b1, "R6 load while selected", cs_n, 1);
          chk(since_rise >= 4, "R6 last rise to load", since_rise, 4);
          chk(got[13:12] == 2'b00, "R2 pad bits", got[13:12], 0);
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected load", got, 0);
          else begin
            logic [13:0] e;
            e = exp_q.pop_front();
            chk({got[15:14], got[11:0]} == e, "R2 frame content", {got[15:14], got[11:0]}, e);
          end
        end else chk(run_ld == LDW, "R6 load width", run_ld, LDW);
        run_ld = 1;
      end else run_ld++;
      if (lddac_n !== p_upd) begin
        if (lddac_n) begin
          chk(run_upd == LDDW, "R7 update width", run_upd, LDDW);
          upd_seen++;
        end
        run_upd = 1;
      end else run_upd++;
      if (rstsel !== p_rs) run_rs = 1; else run_rs++;
      if (drst_n !== p_rst) begin
        if (!drst_n) begin
          chk(rstsel == exp_rsel, "R8 reset level", rstsel, exp_rsel);
          chk(run_rs >= 7, "R8 level setup", run_rs, 7);
        end else begin
          chk(run_rst == RSTW, "R8 reset width", run_rst, RSTW);
          rst_seen++;
        end
        run_rst = 1;
      end else run_rst++;
      p_cs = cs_n; p_sck = sck; p_sdi = sdi; p_ld = ldreg_n; p_upd = lddac_n; p_rst = drst_n; p_rs = rstsel;
    end
  end

  task automatic write(input logic [1:0] ch, input logic [11:0] code, input logic au);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_chan = ch; in_code = code; auto_upd = au;
    exp_q.push_back({ch, code});
    if (au) exp_upd++;
    @(negedge clk);
    in_valid = 1'b0; auto_upd = 1'b0;
    chk(!in_ready, "R9 ready drops after accept", in_ready, 0);
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_req = 1'b1; exp_upd++;
    @(negedge clk); upd_req = 1'b0;
  endtask

  task automatic pulse_rst(input logic m);
    @(negedge clk); rst_req = 1'b1; rst_mode = m; exp_rsel = m;
    @(negedge clk); rst_req = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({cs_n, sck, ldreg_n, lddac_n, drst_n} == 5'h1F, "R1 idle pins", {cs_n, sck, ldreg_n, lddac_n, drst_n}, 31);
    chk(sdi == 1'b0 && rstsel == 1'b0, "R1 data and level low", {sdi, rstsel}, 0);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);

    write(2'd0, 12'hABC, 1'b0);
    wait_idle();
    chk(upd_seen == 0, "R7 no update without request", upd_seen, 0);

    write(2'd3, 12'h001, 1'b1);
    write(2'd1, 12'hFFF, 1'b0);
    write(2'd2, 12'h800, 1'b1);
    wait_idle();
    chk(upd_seen == exp_upd, "R7 auto updates", upd_seen, exp_upd);

    begin
      int f0;
      f0 = frames;
      pulse_upd();
      wait_idle();
      chk(upd_seen == exp_upd, "R7 standalone update", upd_seen, exp_upd);
      chk(frames == f0, "R7 update without frame", frames, f0);
    end

    pulse_rst(1'b1);
    wait_idle();
    chk(rst_seen == 1, "R8 reset served", rst_seen, 1);

    // Reset during a frame must be served before the next write.
    write(2'd1, 12'h5A5, 1'b0);
    repeat (60) @(negedge clk);
    pulse_rst(1'b0);
    write(2'd2, 12'h3C3, 1'b0);
    chk(rst_seen == 2, "R8 reset before next write", rst_seen, 2);
    wait_idle();

    // Update requested mid-frame follows the register load.
    write(2'd0, 12'h000, 1'b0);
    repeat (40) @(negedge clk);
    pulse_upd();
    wait_idle();
    chk(upd_seen == exp_upd, "R7 held update served", upd_seen, exp_upd);

    chk(exp_q.size() == 0, "R2 all frames loaded", exp_q.size(), 0);
    chk(frames == 7, "R3 frame count", frames, 7);
    chk(!busy_seen, "R9 ready only when quiet", busy_seen, 0);
    chk(!(cs_n == 1'b0 && ldreg_n == 1'b0), "R10 exclusive strobes", 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule